// File: doc/BRIEF.md
# Escaped Extraction Stream Frame Decoder

This block turns the raw word stream read out of a switch's CPU extraction queue into clean frames for a downstream sink. The incoming 32-bit words carry their own control: a small band of reserved values stands for end-of-frame (with a count of valid bytes), pruned end, abort, escape and "not ready". The decoder strips this in-band signalling. It captures the four-word header that opens every frame, decodes the header into frame length, ingress port, VLAN ID, tag type and a 32-bit timestamp, and then forwards the payload as beats with byte enables and a last flag. It reports errors as one-cycle pulses that carry a code.

Both stream sides use valid/ready. A word is taken on `src_*` in a cycle where `src_valid` and `src_ready` are both high. A beat leaves on `snk_*` in a cycle where `snk_valid` and `snk_ready` are both high. Once offered, a beat holds still until the sink takes it. Back-pressure reaches the source: `src_ready` drops while the output register is full and blocked, or while a second beat produced by one end-of-frame word is still waiting. The decoder keeps one payload word back inside the block so that it can remove the 4-byte FCS, even when that FCS is split across the last two words. The `cfg_keep_fcs` input chooses whether the FCS is forwarded or stripped.

Top module: `exs_frame_decoder`

## Requirements
- R1: Input words are classified as follows. 0x80000000, 0x80000001, 0x80000002 and 0x80000003 are end-of-frame codes with 4, 3, 2 and 1 valid bytes. 0x80000004 is a pruned end with 4 valid bytes. 0x80000005 is abort, 0x80000006 is escape and 0x80000007 is not-ready. Every other value is plain data.
- R2: The first four data words of a frame form the header. Word 0 and word 1 are the high and low halves of header part A. Word 2 and word 3 are the high and low halves of part B. `hdr_ts` is A[52:21]. `hdr_port` is B[46:43], `hdr_tag` is B[16] and `hdr_vid` is B[11:0]. `hdr_valid` pulses for one cycle, one cycle after the fourth word is accepted. The fields then hold until the next header.
- R3: `hdr_len` equals CELL_BYTES × A[14:7] + A[20:15] − 80, with CELL_BYTES = 64 by default.
- R4: The word that follows an escape code is taken literally, whatever its value, as data with 4 valid bytes. This applies in both the header and the payload.
- R5: After an end-of-frame or pruned code, the next word is the final word of the frame. If that word is an escape code, the word after it is the literal final word.
- R6: A not-ready word seen in the payload is consumed and ignored. It produces no beat and no error.
- R7: `err_valid` pulses for one cycle with `err_code`. Code 1 is not-ready inside the header. Code 2 is abort at any point. Code 3 is an end-of-frame or pruned code inside the header.
- R8: After an error with code 1, 2 or 3, the block drains. `src_ready` follows `src_present`, and every accepted word is discarded. The held-back payload word is dropped. The block returns to header capture once `src_present` is low.
- R9: With `cfg_keep_fcs` = 1, every payload word and the final word are forwarded. The final word is the last beat, and its enable has one bit per valid byte. `snk_be[3]` covers `snk_data[31:24]`, the first byte, so the valid shapes are 1000, 1100, 1110 and 1111.
- R10: With `cfg_keep_fcs` = 0, the final word is dropped. The word before it becomes the last beat, with the enable shape of the final word's byte count. A frame that has no word before its final word emits no beat.
- R11: If 4 × (payload words before the final word) + the final byte count differs from `hdr_len`, the block pulses code 4 after the final word. The frame is still delivered and no drain follows.
- R12: Once `snk_valid` is raised, it and `snk_data`, `snk_be` and `snk_last` stay unchanged until `snk_ready` is high. Every beat that is not last has `snk_be` = 1111. After reset, `snk_valid`, `hdr_valid` and `err_valid` are low and `src_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_keep_fcs | input | 1 | 1: forward FCS bytes, 0: strip them |
| src_present | input | 1 | Source still holds words; governs the drain |
| src_valid | input | 1 | Input word valid |
| src_ready | output | 1 | Input word accepted when high with src_valid |
| src_data | input | 32 | Input word |
| snk_valid | output | 1 | Output beat valid |
| snk_ready | input | 1 | Sink accepts beat |
| snk_data | output | 32 | Output beat data, first byte in bits 31:24 |
| snk_be | output | 4 | Byte enables, bit 3 is first byte |
| snk_last | output | 1 | Final beat of frame |
| hdr_valid | output | 1 | One-cycle pulse: header fields updated |
| hdr_len | output | 16 | Decoded frame length including FCS |
| hdr_port | output | 4 | Ingress port |
| hdr_vid | output | 12 | VLAN ID |
| hdr_tag | output | 1 | Tag type |
| hdr_ts | output | 32 | Timestamp |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Error code, valid with err_valid |

## Verification
The hardest state to reach is the combination of the keep-FCS mode and an end-of-frame word that arrives while a payload word is held back and the sink is stalling. That combination is the only one in which a single input word yields two output beats, and in which `src_ready` must drop for a reason other than a full output. The bench reaches it by pairing vectors that keep the FCS with a sink-ready pattern that drops one cycle in three. It then checks every beat's data, enables and last flag. The drain state is reached with an abort that follows two payload words while `src_present` is held high, which forces the junk words to be consumed. The escaped final word is reached by sending reserved values as payload, so that the bench itself has to escape them.

// File: rtl/exs_pkg.sv
package exs_pkg;

  typedef enum logic [2:0] {
    WC_DATA,
    WC_EOF,
    WC_PRUNED,
    WC_ABORT,
    WC_ESC,
    WC_NOTRDY
  } wclass_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_HDR_NOTRDY = 3'd1,
    ERR_ABORT      = 3'd2,
    ERR_HDR_CODE   = 3'd3,
    ERR_LEN        = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_HDR_ESC,
    ST_DATA,
    ST_ESC,
    ST_FINAL,
    ST_FINAL_ESC,
    ST_DRAIN
  } state_e;

  // Enable shape for n valid bytes, first byte in the top lane.
  function automatic logic [3:0] be_mask(input logic [2:0] n);
    case (n)
      3'd1:    be_mask = 4'b1000;
      3'd2:    be_mask = 4'b1100;
      3'd3:    be_mask = 4'b1110;
      default: be_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/exs_word_class.sv
module exs_word_class
  import exs_pkg::*;
#(
  parameter logic [31:0] CODE_BASE = 32'h8000_0000
) (
  input  logic [31:0] word,
  output wclass_e     wclass,
  output logic [2:0]  nbytes
);
  localparam logic [28:0] BASE_HI = CODE_BASE[31:3];

  logic reserved;
  assign reserved = (word[31:3] == BASE_HI);

  always_comb begin
    wclass = WC_DATA;
    nbytes = 3'd4;
    if (reserved) begin
      case (word[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: begin
          wclass = WC_EOF;
          nbytes = 3'd4 - {1'b0, word[1:0]};
        end
        3'd4:    wclass = WC_PRUNED;
        3'd5:    wclass = WC_ABORT;
        3'd6:    wclass = WC_ESC;
        default: wclass = WC_NOTRDY;
      endcase
    end
  end

endmodule

// File: rtl/exs_hdr_capture.sv
module exs_hdr_capture #(
  parameter int CELL_BYTES = 64,
  parameter int LEN_W      = 16,
  parameter int HDR_WORDS  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         word_we,
  input  logic [$clog2(HDR_WORDS)-1:0] word_idx,
  input  logic [31:0]                  word,
  output logic                         hdr_valid,
  output logic [LEN_W-1:0]             hdr_len,
  output logic [3:0]                   hdr_port,
  output logic [11:0]                  hdr_vid,
  output logic                         hdr_tag,
  output logic [31:0]                  hdr_ts
);
  localparam int IDX_W = $clog2(HDR_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_WORDS - 1);
  localparam logic [LEN_W-1:0] CELL_L = LEN_W'(CELL_BYTES);
  localparam logic [LEN_W-1:0] HDR_OFFS = LEN_W'(80);

  logic [31:0] wbuf [HDR_WORDS-1];
  logic [63:0] part_a, part_b;

  assign part_a = {wbuf[0], wbuf[1]};
  assign part_b = {wbuf[2], word};

  for (genvar g = 0; g < HDR_WORDS - 1; g++) begin : g_wbuf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     wbuf[g] <= '0;
      else if (word_we && word_idx == IDX_W'(g))      wbuf[g] <= word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_valid <= 1'b0;
      hdr_len   <= '0;
      hdr_port  <= '0;
      hdr_vid   <= '0;
      hdr_tag   <= 1'b0;
      hdr_ts    <= '0;
    end else begin
      hdr_valid <= 1'b0;
      if (word_we && word_idx == LAST_IDX) begin
        hdr_valid <= 1'b1;
        hdr_len   <= LEN_W'(part_a[14:7]) * CELL_L + LEN_W'(part_a[20:15]) - HDR_OFFS;
        hdr_ts    <= part_a[52:21];
        hdr_port  <= part_b[46:43];
        hdr_tag   <= part_b[16];
        hdr_vid   <= part_b[11:0];
      end
    end
  end

  AST_HDR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid); // R2

endmodule

// File: rtl/exs_beat_stage.sv
module exs_beat_stage
  import exs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keep_fcs,
  input  logic              push_data,
  input  logic              push_final,
  input  logic              drop,
  input  logic [DATA_W-1:0] word,
  input  logic [2:0]        fin_n,
  output logic              can_take,
  input  logic              snk_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  output logic [BE_W-1:0]   snk_be,
  output logic              snk_last
);
  localparam logic [BE_W-1:0] BE_FULL = '1;

  logic              hold_v;
  logic [DATA_W-1:0] hold_d;
  logic              pend_v;
  logic [DATA_W-1:0] pend_d;
  logic [BE_W-1:0]   pend_be;
  logic              slot_free;

  assign slot_free = !snk_valid || snk_ready;
  assign can_take  = slot_free && !pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_d    <= '0;
      pend_v    <= 1'b0;
      pend_d    <= '0;
      pend_be   <= '0;
      snk_valid <= 1'b0;
      snk_data  <= '0;
      snk_be    <= '0;
      snk_last  <= 1'b0;
    end else begin
      if (snk_valid && snk_ready) snk_valid <= 1'b0;
      if (pend_v && slot_free) begin
        snk_valid <= 1'b1;
        snk_data  <= pend_d;
        snk_be    <= pend_be;
        snk_last  <= 1'b1;
        pend_v    <= 1'b0;
      end else if (push_data) begin
        if (hold_v) begin
          snk_valid <= 1'b1;
          snk_data  <= hold_d;
          snk_be    <= BE_FULL;
          snk_last  <= 1'b0;
        end
        hold_v <= 1'b1;
        hold_d <= word;
      end else if (push_final) begin
        hold_v <= 1'b0;
        if (keep_fcs) begin
          if (hold_v) begin
            snk_valid <= 1'b1;
            snk_data  <= hold_d;
            snk_be    <= BE_FULL;
            snk_last  <= 1'b0;
            pend_v    <= 1'b1;
            pend_d    <= word;
            pend_be   <= be_mask(fin_n);
          end else begin
            snk_valid <= 1'b1;
            snk_data  <= word;
            snk_be    <= be_mask(fin_n);
            snk_last  <= 1'b1;
          end
        end else if (hold_v) begin
          snk_valid <= 1'b1;
          snk_data  <= hold_d;
          snk_be    <= be_mask(fin_n);
          snk_last  <= 1'b1;
        end
      end else if (drop) begin
        hold_v <= 1'b0;
      end
    end
  end

  AST_SNK_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid && !snk_ready |=> snk_valid && $stable(snk_data) && $stable(snk_be)
                                && $stable(snk_last)); // R12
  AST_MID_BEAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid && !snk_last |-> snk_be == BE_FULL); // R12
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid |-> (snk_be == 4'b1000 || snk_be == 4'b1100 || snk_be == 4'b1110
                   || snk_be == 4'b1111)); // R9
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (push_data || push_final) |-> can_take); // R12

endmodule

// File: rtl/exs_frame_decoder.sv
module exs_frame_decoder
  import exs_pkg::*;
#(
  parameter int          CELL_BYTES = 64,
  parameter int          LEN_W      = 16,
  parameter logic [31:0] CODE_BASE  = 32'h8000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_keep_fcs,
  input  logic             src_present,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [31:0]      src_data,
  output logic             snk_valid,
  input  logic             snk_ready,
  output logic [31:0]      snk_data,
  output logic [3:0]       snk_be,
  output logic             snk_last,
  output logic             hdr_valid,
  output logic [LEN_W-1:0] hdr_len,
  output logic [3:0]       hdr_port,
  output logic [11:0]      hdr_vid,
  output logic             hdr_tag,
  output logic [31:0]      hdr_ts,
  output logic             err_valid,
  output logic [2:0]       err_code
);
  localparam int HDR_WORDS = 4;
  localparam int IDX_W     = $clog2(HDR_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_WORDS - 1);

  state_e           st, nxt_st;
  logic [IDX_W-1:0] hcnt, nxt_hcnt;
  logic [LEN_W-1:0] dbytes;
  logic [2:0]       fin_n;
  wclass_e          wc;
  logic [2:0]       wn;
  logic             acc, can_take;
  logic             cap, p_data, p_fin, drop;
  logic             e_set;
  err_e             e_code;
  logic             len_ok;

  exs_word_class #(.CODE_BASE(CODE_BASE)) i_class (
    .word   (src_data),
    .wclass (wc),
    .nbytes (wn)
  );

  exs_hdr_capture #(
    .CELL_BYTES (CELL_BYTES),
    .LEN_W      (LEN_W),
    .HDR_WORDS  (HDR_WORDS)
  ) i_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_we   (cap),
    .word_idx  (hcnt),
    .word      (src_data),
    .hdr_valid (hdr_valid),
    .hdr_len   (hdr_len),
    .hdr_port  (hdr_port),
    .hdr_vid   (hdr_vid),
    .hdr_tag   (hdr_tag),
    .hdr_ts    (hdr_ts)
  );

  exs_beat_stage #(.DATA_W(32)) i_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .keep_fcs   (cfg_keep_fcs),
    .push_data  (p_data),
    .push_final (p_fin),
    .drop       (drop),
    .word       (src_data),
    .fin_n      (fin_n),
    .can_take   (can_take),
    .snk_ready  (snk_ready),
    .snk_valid  (snk_valid),
    .snk_data   (snk_data),
    .snk_be     (snk_be),
    .snk_last   (snk_last)
  );

  assign src_ready = (st == ST_DRAIN) ? src_present : can_take;
  assign acc       = src_valid && src_ready;
  assign len_ok    = (dbytes + LEN_W'(fin_n)) == hdr_len;

  always_comb begin
    nxt_st   = st;
    nxt_hcnt = hcnt;
    cap      = 1'b0;
    p_data   = 1'b0;
    p_fin    = 1'b0;
    drop     = 1'b0;
    e_set    = 1'b0;
    e_code   = ERR_NONE;
    if (st == ST_DRAIN) begin
      if (!src_present) nxt_st = ST_HDR;
    end else if (acc) begin
      case (st)
        ST_HDR: begin
          case (wc)
            WC_DATA:   cap = 1'b1;
            WC_ESC:    nxt_st = ST_HDR_ESC;
            WC_NOTRDY: begin e_set = 1'b1; e_code = ERR_HDR_NOTRDY; end
            WC_ABORT:  begin e_set = 1'b1; e_code = ERR_ABORT;      end
            default:   begin e_set = 1'b1; e_code = ERR_HDR_CODE;   end
          endcase
        end
        ST_HDR_ESC: begin
          cap    = 1'b1;
          nxt_st = ST_HDR;
        end
        ST_DATA: begin
          case (wc)
            WC_DATA:   p_data = 1'b1;
            WC_ESC:    nxt_st = ST_ESC;
            WC_NOTRDY: ;
            WC_ABORT:  begin e_set = 1'b1; e_code = ERR_ABORT; end
            default:   nxt_st = ST_FINAL;
          endcase
        end
        ST_ESC: begin
          p_data = 1'b1;
          nxt_st = ST_DATA;
        end
        ST_FINAL: begin
          if (wc == WC_ESC) nxt_st = ST_FINAL_ESC;
          else begin
            p_fin  = 1'b1;
            nxt_st = ST_HDR;
          end
        end
        ST_FINAL_ESC: begin
          p_fin  = 1'b1;
          nxt_st = ST_HDR;
        end
        default: nxt_st = ST_HDR;
      endcase
      if (cap) begin
        if (hcnt == LAST_IDX) begin
          nxt_hcnt = '0;
          nxt_st   = ST_DATA;
        end else begin
          nxt_hcnt = hcnt + IDX_W'(1);
        end
      end
      if (e_set) begin
        drop     = 1'b1;
        nxt_hcnt = '0;
        nxt_st   = ST_DRAIN;
      end
      if (p_fin && !len_ok) begin
        e_set  = 1'b1;
        e_code = ERR_LEN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HDR;
      hcnt      <= '0;
      dbytes    <= '0;
      fin_n     <= 3'd4;
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
    end else begin
      st        <= nxt_st;
      hcnt      <= nxt_hcnt;
      err_valid <= e_set;
      if (e_set) err_code <= e_code;
      if (cap && hcnt == LAST_IDX) dbytes <= '0;
      else if (p_data)             dbytes <= dbytes + LEN_W'(4);
      if (acc && st == ST_DATA && (wc == WC_EOF || wc == WC_PRUNED)) fin_n <= wn;
    end
  end

  AST_ERR_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> err_code != ERR_NONE); // R7
  AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN && !snk_valid) |=> !snk_valid); // R8
  AST_DATA_NOTRDY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && st == ST_DATA && wc == WC_NOTRDY) |=> !err_valid); // R6
  AST_HDR_NOTRDY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && st == ST_HDR && wc == WC_NOTRDY) |=> err_valid && err_code == ERR_HDR_NOTRDY); // R7

endmodule

// File: tb/test_exs_frame_decoder.sv
module test_exs_frame_decoder;

  typedef struct packed {
    logic [7:0]  k;
    logic [2:0]  n;
    logic        pruned;
    logic        keep;
    logic        bp;
    logic [31:0] ts;
    logic [3:0]  port;
    logic [11:0] vid;
    logic        tag;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'd3, 3'd4, 1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF, 4'd2,  12'h00A, 1'b1},
    '{8'd3, 3'd2, 1'b0, 1'b0, 1'b1, 32'h0000_0001, 4'd15, 12'hFFF, 1'b0},
    '{8'd5, 3'd1, 1'b0, 1'b1, 1'b1, 32'h8000_0000, 4'd0,  12'h123, 1'b1},
    '{8'd2, 3'd4, 1'b1, 1'b0, 1'b0, 32'h1357_9BDF, 4'd7,  12'h800, 1'b0},
    '{8'd1, 3'd3, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'd9,  12'h001, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_keep_fcs = 1'b1;
  logic        src_present = 1'b0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [31:0] src_data = '0;
  logic        snk_valid;
  logic        snk_ready = 1'b1;
  logic [31:0] snk_data;
  logic [3:0]  snk_be;
  logic        snk_last;
  logic        hdr_valid;
  logic [15:0] hdr_len;
  logic [3:0]  hdr_port;
  logic [11:0] hdr_vid;
  logic        hdr_tag;
  logic [31:0] hdr_ts;
  logic        err_valid;
  logic [2:0]  err_code;

  int checks = 0;
  int fails = 0;
  int hdr_cnt = 0;
  int hold_viol = 0;
  bit bp_on = 1'b0;
  int bp_cnt = 0;

  logic [31:0] bq_d[$];
  logic [3:0]  bq_be[$];
  logic        bq_l[$];
  logic [2:0]  eq[$];
  logic [31:0] ed[$];
  logic [3:0]  eb[$];
  logic        el[$];

  logic        pv, pr, pl;
  logic [31:0] pd;
  logic [3:0]  pb;

  exs_frame_decoder i_exs_frame_decoder (
    .clk (clk), .rst_n (rst_n), .cfg_keep_fcs (cfg_keep_fcs),
    .src_present (src_present), .src_valid (src_valid), .src_ready (src_ready),
    .src_data (src_data), .snk_valid (snk_valid), .snk_ready (snk_ready),
    .snk_data (snk_data), .snk_be (snk_be), .snk_last (snk_last),
    .hdr_valid (hdr_valid), .hdr_len (hdr_len), .hdr_port (hdr_port),
    .hdr_vid (hdr_vid), .hdr_tag (hdr_tag), .hdr_ts (hdr_ts),
    .err_valid (err_valid), .err_code (err_code)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    bp_cnt++;
    snk_ready = bp_on ? ((bp_cnt % 3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr && !(snk_valid && snk_data == pd && snk_be == pb && snk_last == pl))
        hold_viol++;
      pv = snk_valid; pr = snk_ready; pd = snk_data; pb = snk_be; pl = snk_last;
      if (snk_valid && snk_ready) begin
        bq_d.push_back(snk_data); bq_be.push_back(snk_be); bq_l.push_back(snk_last);
      end
      if (err_valid) eq.push_back(err_code);
      if (hdr_valid) hdr_cnt++;
    end else begin
      pv = 1'b0; pr = 1'b1; pd = '0; pb = '0; pl = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] bmask(input int n);
    case (n)
      1: return 4'b1000;
      2: return 4'b1100;
      3: return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] pat(input int v, input int i);
    return 32'h3C00_0000 | (32'(v) << 8) | 32'(i);
  endfunction

  function automatic bit is_rsv(input logic [31:0] w);
    return w[31:3] == 29'h1000_0000;
  endfunction

  task automatic put(input logic [31:0] w);
    src_data  = w;
    src_valid = 1'b1;
    do @(negedge clk); while (!src_ready);
    @(posedge clk);
    #2;
    src_valid = 1'b0;
  endtask

  task automatic put_lit(input logic [31:0] w);
    if (is_rsv(w)) put(32'h8000_0006);
    put(w);
  endtask

  task automatic send_hdr(input int len, input logic [31:0] ts, input logic [3:0] port,
                          input logic [11:0] vid, input logic tag);
    int tot;
    logic [7:0]  c;
    logic [5:0]  lb;
    logic [63:0] a, b;
    tot = len + 80;
    c   = 8'(tot / 64);
    lb  = 6'(tot % 64);
    a   = {11'd0, ts, lb, c, 7'd0};
    b   = '0;
    b[46:43] = port;
    b[16]    = tag;
    b[11:0]  = vid;
    put(a[63:32]); put(a[31:0]); put(b[63:32]); put(b[31:0]);
  endtask

  task automatic send_final(input int n, input bit pruned, input logic [31:0] w);
    put(pruned ? 32'h8000_0004 : (32'h8000_0000 + 32'(4 - n)));
    put_lit(w);
  endtask

  task automatic settle();
    repeat (30) @(posedge clk);
    #2;
  endtask

  task automatic clear_all();
    bq_d.delete(); bq_be.delete(); bq_l.delete(); eq.delete();
    ed.delete(); eb.delete(); el.delete();
  endtask

  task automatic cmp_beats(input string req);
    chk(bq_d.size() == ed.size(), {req, " beat count"}, 64'(bq_d.size()), 64'(ed.size()));
    for (int i = 0; i < ed.size() && i < bq_d.size(); i++) begin
      chk(bq_d[i] == ed[i], {req, " beat data"}, 64'(bq_d[i]), 64'(ed[i]));
      chk(bq_be[i] == eb[i], {req, " beat enables"}, 64'(bq_be[i]), 64'(eb[i]));
      chk(bq_l[i] == el[i], {req, " beat last"}, 64'(bq_l[i]), 64'(el[i]));
    end
  endtask

  task automatic expect_frame(input logic [31:0] words[$], input int n, input bit keep);
    int k;
    k = words.size() - 1;
    if (keep) begin
      for (int i = 0; i < k; i++) begin ed.push_back(words[i]); eb.push_back(4'hF); el.push_back(1'b0); end
      ed.push_back(words[k]); eb.push_back(bmask(n)); el.push_back(1'b1);
    end else if (k >= 1) begin
      for (int i = 0; i < k - 1; i++) begin ed.push_back(words[i]); eb.push_back(4'hF); el.push_back(1'b0); end
      ed.push_back(words[k-1]); eb.push_back(bmask(n)); el.push_back(1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w[$];
    int h0;
    repeat (5) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(snk_valid == 1'b0, "R12 reset snk_valid", 64'(snk_valid), 0);
    chk(hdr_valid == 1'b0, "R12 reset hdr_valid", 64'(hdr_valid), 0);
    chk(err_valid == 1'b0, "R12 reset err_valid", 64'(err_valid), 0);
    chk(src_ready == 1'b1, "R12 reset src_ready", 64'(src_ready), 1);
    @(posedge clk); #2;

    // Table walk: R2 R3 R9 R10 R1 (EOF and pruned codes), R12 with back-pressure
    for (int v = 0; v < NV; v++) begin
      vec_t e;
      int len;
      e = VECS[v];
      clear_all();
      w.delete();
      cfg_keep_fcs = e.keep;
      bp_on = e.bp;
      len = 4 * int'(e.k) + int'(e.n);
      h0 = hdr_cnt;
      send_hdr(len, e.ts, e.port, e.vid, e.tag);
      for (int i = 0; i <= int'(e.k); i++) w.push_back(pat(v, i));
      for (int i = 0; i < int'(e.k); i++) put_lit(w[i]);
      send_final(int'(e.n), e.pruned, w[e.k]);
      expect_frame(w, int'(e.n), e.keep);
      settle();
      chk(hdr_cnt == h0 + 1, "R2 header pulse count", 64'(hdr_cnt - h0), 1);
      chk(hdr_len == 16'(len), "R3 frame length", 64'(hdr_len), 64'(len));
      chk(hdr_ts == e.ts, "R2 timestamp", 64'(hdr_ts), 64'(e.ts));
      chk(hdr_port == e.port, "R2 port", 64'(hdr_port), 64'(e.port));
      chk(hdr_vid == e.vid, "R2 vid", 64'(hdr_vid), 64'(e.vid));
      chk(hdr_tag == e.tag, "R2 tag", 64'(hdr_tag), 64'(e.tag));
      cmp_beats(e.keep ? "R9 keep FCS" : "R10 strip FCS");
      chk(eq.size() == 0, "R11 matching length no error", 64'(eq.size()), 0);
    end
    bp_on = 1'b0;

    // R4 R5 R1: reserved values carried as escaped payload, escaped final word
    clear_all(); w.delete();
    cfg_keep_fcs = 1'b1;
    send_hdr(14, 32'h0, 4'd1, 12'd5, 1'b0);
    w.push_back(pat(9, 0)); w.push_back(32'h8000_0005); w.push_back(32'h8000_0007);
    w.push_back(32'h8000_0006);
    for (int i = 0; i < 3; i++) put_lit(w[i]);
    send_final(2, 1'b0, w[3]);
    expect_frame(w, 2, 1'b1);
    settle();
    cmp_beats("R4 R5 escaped words");
    chk(eq.size() == 0, "R4 escape raises no error", 64'(eq.size()), 0);

    // R6: not-ready words inside payload are ignored
    clear_all(); w.delete();
    cfg_keep_fcs = 1'b0;
    bp_on = 1'b1;
    send_hdr(12, 32'h55, 4'd3, 12'd7, 1'b1);
    w.push_back(pat(10, 0)); w.push_back(pat(10, 1)); w.push_back(pat(10, 2));
    put(w[0]); put(32'h8000_0007); put(w[1]); put(32'h8000_0007); put(32'h8000_0007);
    send_final(4, 1'b0, w[2]);
    expect_frame(w, 4, 1'b0);
    settle();
    bp_on = 1'b0;
    cmp_beats("R6 not-ready skipped");
    chk(eq.size() == 0, "R6 no error for payload not-ready", 64'(eq.size()), 0);

    // R7: not-ready inside header, then recover
    clear_all();
    src_present = 1'b0;
    put(32'h0000_1111); put(32'h8000_0007);
    settle();
    chk(eq.size() == 1 && eq[0] == 3'd1, "R7 header not-ready code",
        64'(eq.size() > 0 ? eq[0] : 3'd7), 1);

    // R7: end-of-frame code inside header
    clear_all();
    put(32'h8000_0001);
    settle();
    chk(eq.size() == 1 && eq[0] == 3'd3, "R7 header EOF code",
        64'(eq.size() > 0 ? eq[0] : 3'd7), 3);

    // R8 R7: abort mid-payload with drain of junk words
    clear_all();
    cfg_keep_fcs = 1'b1;
    src_present = 1'b1;
    send_hdr(20, 32'h9, 4'd4, 12'd9, 1'b0);
    put(pat(11, 0)); put(pat(11, 1)); put(32'h8000_0005);
    put(pat(11, 2)); put(32'h8000_0000); put(pat(11, 3));
    settle();
    chk(eq.size() == 1 && eq[0] == 3'd2, "R7 abort code",
        64'(eq.size() > 0 ? eq[0] : 3'd7), 2);
    ed.push_back(pat(11, 0)); eb.push_back(4'hF); el.push_back(1'b0);
    cmp_beats("R8 drained words discarded");
    chk(src_ready == 1'b1, "R8 ready follows present while draining", 64'(src_ready), 1);
    src_present = 1'b0;
    @(posedge clk); #2;
    clear_all(); w.delete();
    h0 = hdr_cnt;
    send_hdr(8, 32'hABCD, 4'd6, 12'd66, 1'b1);
    w.push_back(pat(12, 0)); w.push_back(pat(12, 1));
    put_lit(w[0]);
    send_final(4, 1'b0, w[1]);
    expect_frame(w, 4, 1'b1);
    settle();
    chk(hdr_cnt == h0 + 1 && hdr_port == 4'd6, "R8 header after drain",
        64'(hdr_port), 6);
    cmp_beats("R8 frame after drain");

    // R11: header length disagrees with received bytes
    clear_all(); w.delete();
    send_hdr(20, 32'h1, 4'd1, 12'd1, 1'b0);
    w.push_back(pat(13, 0)); w.push_back(pat(13, 1)); w.push_back(pat(13, 2));
    put_lit(w[0]); put_lit(w[1]);
    send_final(4, 1'b0, w[2]);
    expect_frame(w, 4, 1'b1);
    settle();
    chk(eq.size() == 1 && eq[0] == 3'd4, "R11 length mismatch code",
        64'(eq.size() > 0 ? eq[0] : 3'd7), 4);
    cmp_beats("R11 frame still delivered");

    // R10: strip mode with only a final word emits nothing
    clear_all();
    cfg_keep_fcs = 1'b0;
    send_hdr(4, 32'h2, 4'd2, 12'd2, 1'b0);
    send_final(4, 1'b0, pat(14, 0));
    settle();
    chk(bq_d.size() == 0, "R10 lone final word stripped", 64'(bq_d.size()), 0);
    chk(eq.size() == 0, "R10 lone final no error", 64'(eq.size()), 0);

    chk(hold_viol == 0, "R12 beat held under back-pressure", 64'(hold_viol), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule